// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects up to 32 interrupt request lines, catches a rising edge on each one in a sticky status register, and masks that register with an enable register. A fixed-priority encoder then picks one winner from the bits that are both pending and enabled. The CPU sees a single interrupt line, plus the encoded number of the winning interrupt and a flag that says whether any interrupt is active.

Source bit b of the request bus and of both registers carries interrupt number N_SRC-1-b. So interrupt 0 sits in the most-significant bit and has the highest priority. Software reads the status and enable registers over a simple single-cycle register port. It enables sources by writing the enable register, and acknowledges a source by writing a one to its status bit.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the status register and the enable register both read as zero, cpu_irq_o is 0 and irq_valid_o is 0.
- R2: When req_i[b] goes from 0 to 1 between two clock edges, status bit b is set. A request held high sets the bit only once, so after the bit is cleared it stays clear while the request stays high.
- R3: A status bit stays set until software clears it, whether or not its enable bit is set. A set status bit with its enable bit clear does not raise cpu_irq_o.
- R4: A write to address 0 (the status register) clears every status bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R5: If a rising request edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: A write to address 1 (the enable register) replaces all enable bits with the write data. A read of address 1 returns the full 32-bit enable value, and a read of address 0 returns the full status value.
- R7: cpu_irq_o is 1 exactly when at least one bit is set in both the status and the enable register.
- R8: When some bit is set in both registers, irq_valid_o is 1 and irq_num_o equals N_SRC-1-p, where p is the highest such bit position. The lowest interrupt number therefore wins.
- R9: When no bit is set in both registers, irq_valid_o is 0 and irq_num_o is 0.
- R10: Addresses 2 and 3 are unmapped. Reads there return zero, and writes there change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 32 | Raw interrupt requests; bit b is interrupt 31-b |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address: 0 status, 1 enable |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational, zero when no read is selected |
| cpu_irq_o | output | 1 | Interrupt line to the CPU |
| irq_num_o | output | 5 | Number of the winning interrupt |
| irq_valid_o | output | 1 | A pending, enabled interrupt exists |

## Verification
The bench goes after a clearing write that arrives in the same cycle as a new edge on the same bit. A design that lets the clear win would drop that event, and its status readback would show the bit as zero. It holds a request high across an acknowledge, which catches a level-sensitive design that sets the bit again at once. It sets status bits while they are masked and then enables them, which exposes a design that gates the latching with the enable bit or reports masked bits on the CPU line. Several simultaneous pending bits, including bit 31 together with bit 0, check the encoder direction: a reversed encoder would report the highest-numbered interrupt instead of the lowest. It also writes to the unmapped addresses, where a loose address decode would corrupt a register.

// File: rtl/prio_irq_ctrl_pkg.sv
package prio_irq_ctrl_pkg;
  localparam int unsigned ADDR_W      = 2;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd1;

  typedef enum logic [1:0] {
    REG_NONE   = 2'd0,
    REG_STATUS = 2'd1,
    REG_ENABLE = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/prio_irq_rst_sync.sv
module prio_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/prio_irq_edge.sv
module prio_irq_edge #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] req_i,
  output logic [WIDTH-1:0] prev_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;
  logic             prev_en;

  always_comb begin
    prev_d  = req_i;
    prev_en = (prev_q != req_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= '0;
    else if (prev_en) prev_q <= prev_d;
  end

  assign rise_o = req_i & ~prev_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/prio_irq_status.sv
module prio_irq_status #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] status_o
);
  logic [WIDTH-1:0] status_q;
  logic [WIDTH-1:0] status_d;
  logic             status_en;

  always_comb begin
    // a set in the same cycle overrides the clear for that bit
    status_d  = (status_q & ~clr_i) | set_i;
    status_en = (|set_i) | (|clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (status_en) status_q <= status_d;
  end

  assign status_o = status_q;
endmodule

// File: rtl/prio_irq_encoder.sv
module prio_irq_encoder #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned NUM_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] pend_i,
  output logic [NUM_W-1:0] num_o,
  output logic             valid_o
);
  always_comb begin
    num_o   = '0;
    valid_o = 1'b0;
    // walk upward; later (higher) bits overwrite, so the top set bit wins
    for (int b = 0; b < int'(WIDTH); b++) begin
      if (pend_i[b]) begin
        valid_o = 1'b1;
        num_o   = NUM_W'(int'(WIDTH) - 1 - b);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_ctrl_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  localparam int unsigned NUM_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [N_SRC-1:0]  bus_wdata_i,
  output logic [N_SRC-1:0]  bus_rdata_o,
  output logic              cpu_irq_o,
  output logic [NUM_W-1:0]  irq_num_o,
  output logic              irq_valid_o
);
  logic             rst_n_s;
  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] rise;
  logic [N_SRC-1:0] clr_mask;
  logic [N_SRC-1:0] status_q;
  logic [N_SRC-1:0] enable_q;
  logic [N_SRC-1:0] enable_d;
  logic             enable_en;
  logic [N_SRC-1:0] pend;
  reg_sel_e         reg_sel;

  prio_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  prio_irq_edge #(.WIDTH(N_SRC)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .req_i  (req_i),
    .prev_o (prev_q),
    .rise_o (rise)
  );

  always_comb begin
    unique case (bus_addr_i)
      ADDR_STATUS: reg_sel = REG_STATUS;
      ADDR_ENABLE: reg_sel = REG_ENABLE;
      default:     reg_sel = REG_NONE;
    endcase
  end

  always_comb begin
    clr_mask  = '0;
    enable_en = 1'b0;
    enable_d  = bus_wdata_i;
    if (bus_sel_i && bus_we_i) begin
      if (reg_sel == REG_STATUS) clr_mask  = bus_wdata_i;
      if (reg_sel == REG_ENABLE) enable_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)       enable_q <= '0;
    else if (enable_en) enable_q <= enable_d;
  end

  prio_irq_status #(.WIDTH(N_SRC)) u_status (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .set_i    (rise),
    .clr_i    (clr_mask),
    .status_o (status_q)
  );

  assign pend      = status_q & enable_q;
  assign cpu_irq_o = |pend;

  prio_irq_encoder #(.WIDTH(N_SRC)) u_enc (
    .pend_i  (pend),
    .num_o   (irq_num_o),
    .valid_o (irq_valid_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_we_i) begin
      unique case (reg_sel)
        REG_STATUS: bus_rdata_o = status_q;
        REG_ENABLE: bus_rdata_o = enable_q;
        default:    bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import prio_irq_ctrl_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  localparam int unsigned NUM_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic [N_SRC-1:0]  req_i,
  input logic [N_SRC-1:0]  prev_q,
  input logic [N_SRC-1:0]  status_q,
  input logic [N_SRC-1:0]  enable_q,
  input logic [N_SRC-1:0]  clr_mask,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [N_SRC-1:0]  bus_wdata_i,
  input logic              cpu_irq_o,
  input logic [NUM_W-1:0]  irq_num_o,
  input logic              irq_valid_o
);
  logic [N_SRC-1:0] pend_c;
  logic [N_SRC-1:0] edges_c;
  int unsigned      win_pos;
  assign pend_c  = status_q & enable_q;
  assign edges_c = req_i & ~prev_q;
  assign win_pos = N_SRC - 1 - int'(irq_num_o);

  always @(posedge clk) begin
    if (rst_n_s === 1'b0)
      assert_reset_clear_R1: assert (status_q == '0 && enable_q == '0)
        else $error("registers not clear in reset");
  end

  assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (edges_c != '0) |=> ((status_q & $past(edges_c)) == $past(edges_c)));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    1'b1 |=> ((~status_q & $past(status_q & ~clr_mask)) == '0));

  assert_enable_write_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_sel_i && bus_we_i && bus_addr_i == ADDR_ENABLE) |=> (enable_q == $past(bus_wdata_i)));

  assert_line_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    cpu_irq_o == irq_valid_o);

  assert_winner_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_valid_o |-> ((pend_c >> win_pos) == N_SRC'(1)));

  assert_none_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pend_c == '0) |-> (!irq_valid_o && irq_num_o == '0 && !cpu_irq_o));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk         (clk),
  .rst_n_s     (rst_n_s),
  .req_i       (req_i),
  .prev_q      (prev_q),
  .status_q    (status_q),
  .enable_q    (enable_q),
  .clr_mask    (clr_mask),
  .bus_sel_i   (bus_sel_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .cpu_irq_o   (cpu_irq_o),
  .irq_num_o   (irq_num_o),
  .irq_valid_o (irq_valid_o)
);

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/100ps
module prio_irq_ctrl_tb_top;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req;
  logic          sel;
  logic          we;
  logic [1:0]    addr;
  logic [N-1:0]  wdata;
  logic [N-1:0]  rdata;
  logic          cpu_irq;
  logic [4:0]    num;
  logic          valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [N-1:0] m_stat;
  logic [N-1:0] m_en;
  logic [N-1:0] m_prev;

  always #2 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .cpu_irq_o(cpu_irq), .irq_num_o(num), .irq_valid_o(valid)
  );

  function automatic int exp_num(input logic [N-1:0] p);
    for (int b = N-1; b >= 0; b--) if (p[b]) return N-1-b;
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] v);
    sel = 1'b1; we = 1'b0; addr = a;
    #0.3;
    v = rdata;
  endtask

  task automatic check_all(input string stag);
    logic [N-1:0] v;
    logic [N-1:0] p;
    p = m_stat & m_en;
    chk("R7 cpu_irq", {31'd0, cpu_irq}, {31'd0, |p});
    if (|p) begin
      chk("R8 valid", {31'd0, valid}, 32'd1);
      chk("R8 num", {27'd0, num}, 32'(exp_num(p)));
    end else begin
      chk("R9 valid", {31'd0, valid}, 32'd0);
      chk("R9 num", {27'd0, num}, 32'd0);
    end
    rd(2'd0, v); chk(stag, v, m_stat);
    rd(2'd1, v); chk("R6 enable readback", v, m_en);
    rd(2'd2, v); chk("R10 unmapped read", v, '0);
    rd(2'd3, v); chk("R10 unmapped read", v, '0);
    sel = 1'b0;
  endtask

  // drive one cycle of stimulus, advance model at the edge, check after
  task automatic step(input logic s, input logic w, input logic [1:0] a,
                      input logic [N-1:0] d, input logic [N-1:0] r, input string stag);
    sel = s; we = w; addr = a; wdata = d; req = r;
    @(posedge clk);
    begin
      logic [N-1:0] clr;
      clr = (s && w && a == 2'd0) ? d : '0;
      m_stat = (m_stat & ~clr) | (r & ~m_prev);
      if (s && w && a == 2'd1) m_en = d;
      m_prev = r;
    end
    @(negedge clk);
    check_all(stag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] r;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; req = '0; sel = 0; we = 0; addr = 0; wdata = '0;
    m_stat = '0; m_en = '0; m_prev = '0;
    repeat (3) @(negedge clk);
    check_all("R1 status at reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 status after reset");

    // R3: latch while masked, no line
    step(0, 0, 0, '0, 32'h0000_0011, "R3 masked latch");
    chk("R3 masked no irq", {31'd0, cpu_irq}, 32'd0);
    step(0, 0, 0, '0, 32'h0000_0000, "R3 stays after req drop");
    // R6 enable, R8 winner bit4 -> num 27
    step(1, 1, 1, 32'h0000_0010, '0, "R6 enable write");
    chk("R8 num bit4", {27'd0, num}, 32'd27);
    step(1, 1, 1, 32'hFFFF_FFFF, '0, "R8 both enabled");
    chk("R8 num bit4 over bit0", {27'd0, num}, 32'd27);
    // R10 unmapped write ignored
    step(1, 1, 2, 32'hFFFF_FFFF, '0, "R10 unmapped write status");
    step(1, 1, 3, 32'h0000_0000, '0, "R10 unmapped write status");
    // R4 partial clear
    step(1, 1, 0, 32'h0000_0010, '0, "R4 clear one bit");
    chk("R4 remaining bit0 num", {27'd0, num}, 32'd31);
    // R8 bit31 with bit0 -> num 0
    step(0, 0, 0, '0, 32'h8000_0000, "R2 set bit31");
    chk("R8 num bit31", {27'd0, num}, 32'd0);
    // R5 set wins over clear: drop bit31 request, then re-raise with clear
    step(0, 0, 0, '0, 32'h0000_0000, "R2 drop");
    step(1, 1, 0, 32'h8000_0001, 32'h8000_0000, "R5 set wins");
    chk("R5 bit31 kept", {31'd0, m_stat[31]}, 32'd1);
    // R2 held-high no re-set after clear
    step(1, 1, 0, 32'h8000_0000, 32'h8000_0000, "R2 clear while held");
    step(0, 0, 0, '0, 32'h8000_0000, "R2 held high no reset");
    chk("R9 none after clear", {31'd0, valid}, 32'd0);
    step(1, 1, 1, 32'h0000_0000, 32'h8000_0000, "R6 disable all");

    // random phase
    r = 32'h8000_0000;
    for (int i = 0; i < 400; i++) begin
      logic [1:0] a;
      logic s;
      r = r ^ ($urandom & $urandom & $urandom);
      s = ($urandom % 3) == 0;
      a = 2'($urandom % 4);
      step(s, s, a, $urandom & $urandom, r, "R2 R4 random status");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule